// File: doc/BRIEF.md
# Pending-to-Message Dispatch Scanner

This block sits between the per-source trigger logic of an interrupt domain and a message-signalled interrupt transport. It holds one pending bit per source. The trigger logic sets these bits, and software clear requests reset them. The block continuously checks which sources are both enabled and pending. While the domain interrupt enable is on, it turns the lowest-numbered such source into one message request on a valid/ready output.

Each request carries the hart index, the guest index and the interrupt identity of the chosen source. The block takes these fields from that source's target word. The pending bit of a source is dropped on the same clock edge on which its request is loaded into the output slot. A separate generate-message request from the register side, with guest index forced to zero, bypasses the scan and wins whenever the output slot is free.

Evaluation runs every cycle. Any change to the enables, the pending bits or the domain enable is therefore seen one edge later, with no separate rescan command.

Top module: `dispatch_scanner`

## Requirements
- R1: While `dom_en` is 0, no scanned source is loaded into the output slot, and no pending bit is cleared except by `pend_clr`.
- R2: A source is dispatched only when its `src_en` bit and its pending bit are both 1. A pending source with `src_en` 0 stays pending and produces no request.
- R3: On the edge where a source's request is loaded (`msg_valid` rises or is reloaded), that source's `pend_q` bit becomes 0.
- R4: Each source i has a target word in `tgt_flat[i*TGT_W +: TGT_W]`. In that word the identity occupies bits [ID_W-1:0], the guest index the next GUEST_W bits, and the hart index the top HART_W bits. A request reports these as `msg_id`, `msg_guest` and `msg_hart`, with `msg_src` = i.
- R5: When several sources are eligible, the lowest index is sent first, then each next higher one.
- R6: While `msg_valid` is 1 and `msg_ready` is 0, the request and all its fields stay unchanged.
- R7: When `gen_req` is 1 and the slot is free, `gen_ack` is 1 in that cycle. The next request is then the generated one (`msg_hart`=`gen_hart`, `msg_id`=`gen_id`, `msg_guest`=0, `msg_src`=0), ahead of any eligible source, and the eligible sources remain pending.
- R8: Source index 0 never becomes pending and is never dispatched.
- R9: `busy` is 1 while any source is eligible or a request is held. It is 0 once all requests have been accepted and none is eligible.
- R10: A `pend_clr` bit removes that source's pending state, so a later domain enable sends nothing for it.
- R11: After reset, `msg_valid`, `busy`, `gen_ack` and all `pend_q` bits are 0.
- R12: With a free slot and `dom_en` 1, a source that becomes eligible at a clock edge is presented on `msg_valid` after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dom_en | input | 1 | Domain interrupt enable |
| src_en | input | NUM_SRC | Per-source enable bits |
| pend_set | input | NUM_SRC | Set pulses from the trigger logic |
| pend_clr | input | NUM_SRC | Clear pulses from the register side |
| tgt_flat | input | NUM_SRC*TGT_W | Per-source target words, source i at slice i |
| gen_req | input | 1 | Generate-message request, held until acknowledged |
| gen_hart | input | HART_W | Hart index for the generated message |
| gen_id | input | ID_W | Identity for the generated message |
| gen_ack | output | 1 | Generated message taken this cycle |
| msg_valid | output | 1 | Request valid |
| msg_ready | input | 1 | Downstream accepts the request |
| msg_hart | output | HART_W | Hart index of the request |
| msg_guest | output | GUEST_W | Guest index of the request |
| msg_id | output | ID_W | Identity of the request |
| msg_src | output | SRC_W | Source index of the request, 0 for generated |
| pend_q | output | NUM_SRC | Current pending bits |
| busy | output | 1 | Eligible source or held request present |

## Verification
The hardest case to reach is a queue of several eligible sources stacked behind a stalled output. The stimulus gets there by setting the pending bits of three sources in one pulse while the domain is off. It then turns the domain on with ready held low, which shows both the ascending order and the held request. Ready is then raised and kept high, so that each accept reloads the slot on the same edge. The priority of the generated message is exercised in the same way: a source is left pending while the domain is off, and the generate request is raised on the same cycle that the domain is turned on.

// File: rtl/dispatch_scan_pkg.sv
package dispatch_scan_pkg;

  typedef enum logic [1:0] {
    LOAD_NONE = 2'd0,
    LOAD_GEN  = 2'd1,
    LOAD_SCAN = 2'd2
  } load_sel_e;

  // take w bits starting at lsb from a 32-bit word
  function automatic logic [31:0] field_of(input logic [31:0] word,
                                           input int lsb, input int w);
    return (word >> lsb) & ((32'd1 << w) - 32'd1);
  endfunction

endpackage

// File: rtl/dispatch_pend_bank.sv
module dispatch_pend_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] sw_clr_i,
  input  logic [N-1:0] issue_clr_i,
  output logic [N-1:0] pend_o
);
  // index 0 is reserved and can never hold state
  localparam logic [N-1:0] IDX0_MASK = {{(N-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o | set_i) & ~sw_clr_i & ~issue_clr_i & ~IDX0_MASK;
  end
endmodule

// File: rtl/dispatch_pick.sv
module dispatch_pick #(
  parameter int N     = 8,
  parameter int SRC_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [SRC_W-1:0] idx_o
);
  // walk downward so the lowest set index is the last one written
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/dispatch_msg_slot.sv
module dispatch_msg_slot
  import dispatch_scan_pkg::*;
#(
  parameter int HART_W  = 4,
  parameter int GUEST_W = 3,
  parameter int ID_W    = 6,
  parameter int SRC_W   = 3,
  localparam int TGT_W  = HART_W + GUEST_W + ID_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               free_i,
  input  load_sel_e          sel_i,
  input  logic [HART_W-1:0]  gen_hart_i,
  input  logic [ID_W-1:0]    gen_id_i,
  input  logic [TGT_W-1:0]   tgt_i,
  input  logic [SRC_W-1:0]   src_i,
  output logic               valid_o,
  output logic [HART_W-1:0]  hart_o,
  output logic [GUEST_W-1:0] guest_o,
  output logic [ID_W-1:0]    id_o,
  output logic [SRC_W-1:0]   src_o
);
  localparam int GUEST_LSB = ID_W;
  localparam int HART_LSB  = ID_W + GUEST_W;

  logic [31:0] tgt32;
  assign tgt32 = 32'(tgt_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      hart_o  <= '0;
      guest_o <= '0;
      id_o    <= '0;
      src_o   <= '0;
    end else if (free_i) begin
      case (sel_i)
        LOAD_GEN: begin
          valid_o <= 1'b1;
          hart_o  <= gen_hart_i;
          guest_o <= '0;
          id_o    <= gen_id_i;
          src_o   <= '0;
        end
        LOAD_SCAN: begin
          valid_o <= 1'b1;
          hart_o  <= HART_W'(field_of(tgt32, HART_LSB, HART_W));
          guest_o <= GUEST_W'(field_of(tgt32, GUEST_LSB, GUEST_W));
          id_o    <= ID_W'(field_of(tgt32, 0, ID_W));
          src_o   <= src_i;
        end
        default: valid_o <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/dispatch_scanner.sv
module dispatch_scanner
  import dispatch_scan_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int HART_W  = 4,
  parameter int GUEST_W = 3,
  parameter int ID_W    = 6,
  localparam int TGT_W  = HART_W + GUEST_W + ID_W,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dom_en,
  input  logic [NUM_SRC-1:0]       src_en,
  input  logic [NUM_SRC-1:0]       pend_set,
  input  logic [NUM_SRC-1:0]       pend_clr,
  input  logic [NUM_SRC*TGT_W-1:0] tgt_flat,
  input  logic                     gen_req,
  input  logic [HART_W-1:0]        gen_hart,
  input  logic [ID_W-1:0]          gen_id,
  output logic                     gen_ack,
  output logic                     msg_valid,
  input  logic                     msg_ready,
  output logic [HART_W-1:0]        msg_hart,
  output logic [GUEST_W-1:0]       msg_guest,
  output logic [ID_W-1:0]          msg_id,
  output logic [SRC_W-1:0]         msg_src,
  output logic [NUM_SRC-1:0]       pend_q,
  output logic                     busy
);
  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC-1:0] issue_vec;
  logic               any_elig;
  logic [SRC_W-1:0]   pick_idx;
  logic               slot_free;
  logic               issue;
  logic [TGT_W-1:0]   pick_tgt;
  load_sel_e          load_sel;

  dispatch_pend_bank #(.N(NUM_SRC)) u_pend (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (pend_set),
    .sw_clr_i    (pend_clr),
    .issue_clr_i (issue_vec),
    .pend_o      (pend_q)
  );

  assign elig = pend_q & src_en;

  dispatch_pick #(.N(NUM_SRC), .SRC_W(SRC_W)) u_pick (
    .req_i (elig),
    .any_o (any_elig),
    .idx_o (pick_idx)
  );

  assign slot_free = !msg_valid || msg_ready;
  assign gen_ack   = slot_free && gen_req;
  assign issue     = slot_free && !gen_req && dom_en && any_elig;
  assign issue_vec = issue ? ({{(NUM_SRC-1){1'b0}}, 1'b1} << pick_idx) : '0;
  assign pick_tgt  = tgt_flat[int'(pick_idx)*TGT_W +: TGT_W];

  always_comb begin
    if (gen_req)    load_sel = LOAD_GEN;
    else if (issue) load_sel = LOAD_SCAN;
    else            load_sel = LOAD_NONE;
  end

  dispatch_msg_slot #(
    .HART_W(HART_W), .GUEST_W(GUEST_W), .ID_W(ID_W), .SRC_W(SRC_W)
  ) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .free_i     (slot_free),
    .sel_i      (load_sel),
    .gen_hart_i (gen_hart),
    .gen_id_i   (gen_id),
    .tgt_i      (pick_tgt),
    .src_i      (pick_idx),
    .valid_o    (msg_valid),
    .hart_o     (msg_hart),
    .guest_o    (msg_guest),
    .id_o       (msg_id),
    .src_o      (msg_src)
  );

  assign busy = any_elig || msg_valid;
endmodule

// File: rtl/dispatch_scanner_chk.sv
module dispatch_scanner_chk #(
  parameter int N       = 8,
  parameter int HART_W  = 4,
  parameter int GUEST_W = 3,
  parameter int ID_W    = 6,
  parameter int SRC_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dom_en,
  input logic [N-1:0]       src_en,
  input logic [N-1:0]       pend_clr,
  input logic               gen_req,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [HART_W-1:0]  msg_hart,
  input logic [GUEST_W-1:0] msg_guest,
  input logic [ID_W-1:0]    msg_id,
  input logic [SRC_W-1:0]   msg_src,
  input logic [N-1:0]       pend_q,
  input logic               issue,
  input logic [N-1:0]       issue_vec
);
  // R6
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable({msg_hart, msg_guest, msg_id, msg_src}));

  // R1
  dom_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dom_en && !gen_req && (!msg_valid || msg_ready) |=> !msg_valid);

  // R1
  dom_off_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dom_en && pend_clr == '0 |=> ($past(pend_q) & ~pend_q) == '0);

  // R3
  issue_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (pend_q & $past(issue_vec)) == '0);

  // R2
  issue_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (issue_vec & src_en & pend_q) != '0 && $onehot0(issue_vec));

  // R7
  gen_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_req && (!msg_valid || msg_ready) |=> msg_valid && msg_src == '0 && msg_guest == '0);
endmodule

bind dispatch_scanner dispatch_scanner_chk #(
  .N(NUM_SRC), .HART_W(HART_W), .GUEST_W(GUEST_W), .ID_W(ID_W), .SRC_W(SRC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dom_en    (dom_en),
  .src_en    (src_en),
  .pend_clr  (pend_clr),
  .gen_req   (gen_req),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_hart  (msg_hart),
  .msg_guest (msg_guest),
  .msg_id    (msg_id),
  .msg_src   (msg_src),
  .pend_q    (pend_q),
  .issue     (issue),
  .issue_vec (issue_vec)
);

// File: tb/dispatch_scanner_tb.sv
module dispatch_scanner_tb;
  localparam int N = 8, HW = 4, GW = 3, IW = 6, TW = HW + GW + IW, SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dom_en = 1'b0;
  logic [N-1:0]  src_en = '1;
  logic [N-1:0]  pend_set = '0;
  logic [N-1:0]  pend_clr = '0;
  logic [N*TW-1:0] tgt_flat;
  logic          gen_req = 1'b0;
  logic [HW-1:0] gen_hart = '0;
  logic [IW-1:0] gen_id = '0;
  logic          gen_ack;
  logic          msg_valid;
  logic          msg_ready = 1'b0;
  logic [HW-1:0] msg_hart;
  logic [GW-1:0] msg_guest;
  logic [IW-1:0] msg_id;
  logic [SW-1:0] msg_src;
  logic [N-1:0]  pend_q;
  logic          busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // target of source i: hart = i+2, guest = i, identity = 10+3i
  function automatic logic [HW-1:0] ex_hart(int i);  return HW'(i + 2);      endfunction
  function automatic logic [GW-1:0] ex_guest(int i); return GW'(i);          endfunction
  function automatic logic [IW-1:0] ex_id(int i);    return IW'(10 + 3 * i); endfunction

  always_comb
    for (int i = 0; i < N; i++)
      tgt_flat[i*TW +: TW] = {ex_hart(i), ex_guest(i), ex_id(i)};

  dispatch_scanner u_dut (
    .clk(clk), .rst_n(rst_n), .dom_en(dom_en), .src_en(src_en),
    .pend_set(pend_set), .pend_clr(pend_clr), .tgt_flat(tgt_flat),
    .gen_req(gen_req), .gen_hart(gen_hart), .gen_id(gen_id), .gen_ack(gen_ack),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_hart(msg_hart),
    .msg_guest(msg_guest), .msg_id(msg_id), .msg_src(msg_src),
    .pend_q(pend_q), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_set(input logic [N-1:0] v);
    pend_set = v; step(1); pend_set = '0;
  endtask

  task automatic check_src(input string tag, input int i);
    eq({tag, " valid"}, int'(msg_valid), 1);
    eq({tag, " src"},   int'(msg_src), i);
    eq({tag, " hart"},  int'(msg_hart), int'(ex_hart(i)));
    eq({tag, " guest"}, int'(msg_guest), int'(ex_guest(i)));
    eq({tag, " id"},    int'(msg_id), int'(ex_id(i)));
  endtask

  task automatic accept_one();
    msg_ready = 1'b1; step(1); msg_ready = 1'b0;
  endtask

  task automatic t_reset();
    eq("R11 valid", int'(msg_valid), 0);
    eq("R11 busy", int'(busy), 0);
    eq("R11 gen_ack", int'(gen_ack), 0);
    eq("R11 pend", int'(pend_q), 0);
  endtask

  task automatic t_domain_off();
    dom_en = 1'b0;
    pulse_set(8'b0000_1000);
    step(4);
    eq("R1 no msg while off", int'(msg_valid), 0);
    eq("R1 pending kept", int'(pend_q[3]), 1);
    eq("R9 busy while eligible", int'(busy), 1);
    dom_en = 1'b1;
    step(1);
    check_src("R12 R4", 3);
    eq("R3 pending cleared on load", int'(pend_q[3]), 0);
    accept_one();
    eq("R9 idle valid", int'(msg_valid), 0);
    eq("R9 idle busy", int'(busy), 0);
  endtask

  task automatic t_enable_gate();
    src_en = 8'b1110_1111;
    pulse_set(8'b0001_0000);
    step(3);
    eq("R2 masked no msg", int'(msg_valid), 0);
    eq("R2 masked still pending", int'(pend_q[4]), 1);
    src_en = '1;
    step(1);
    check_src("R2 after enable", 4);
    accept_one();
  endtask

  task automatic t_order();
    dom_en = 1'b0;
    pulse_set(8'b0110_0100);
    dom_en = 1'b1;
    step(1);
    check_src("R5 first", 2);
    step(3);
    check_src("R6 held", 2);
    eq("R6 others pending", int'(pend_q), 8'b0110_0000);
    msg_ready = 1'b1;
    step(1);
    check_src("R5 second", 5);
    step(1);
    check_src("R5 third", 6);
    step(1);
    msg_ready = 1'b0;
    eq("R5 drained", int'(msg_valid), 0);
  endtask

  task automatic t_gen_prio();
    dom_en = 1'b0;
    pulse_set(8'b0000_0010);
    gen_req = 1'b1; gen_hart = 4'd9; gen_id = 6'd33; dom_en = 1'b1;
    #1;
    eq("R7 gen_ack", int'(gen_ack), 1);
    step(1);
    gen_req = 1'b0;
    eq("R7 gen valid", int'(msg_valid), 1);
    eq("R7 gen src", int'(msg_src), 0);
    eq("R7 gen hart", int'(msg_hart), 9);
    eq("R7 gen guest", int'(msg_guest), 0);
    eq("R7 gen id", int'(msg_id), 33);
    eq("R7 source kept", int'(pend_q[1]), 1);
    msg_ready = 1'b1;
    step(1);
    check_src("R7 source after gen", 1);
    step(1);
    msg_ready = 1'b0;
    eq("R7 drained", int'(msg_valid), 0);
  endtask

  task automatic t_src0();
    dom_en = 1'b1;
    pulse_set(8'b0000_0001);
    eq("R8 no pend 0", int'(pend_q[0]), 0);
    step(2);
    eq("R8 no msg", int'(msg_valid), 0);
  endtask

  task automatic t_sw_clear();
    dom_en = 1'b0;
    pulse_set(8'b1000_0000);
    eq("R10 set", int'(pend_q[7]), 1);
    pend_clr = 8'b1000_0000; step(1); pend_clr = '0;
    eq("R10 cleared", int'(pend_q[7]), 0);
    dom_en = 1'b1;
    step(2);
    eq("R10 no msg", int'(msg_valid), 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_domain_off();
    t_enable_gate();
    t_order();
    t_gen_prio();
    t_src0();
    t_sw_clear();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule